// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a serial EEPROM that sits on a three-wire bus (chip select, serial clock, serial data in) and answers on a fourth wire (serial data out). The storage is a 128-word by 16-bit array of registers. A command frame begins with a start bit, then carries a two-bit opcode and an eight-bit field, sent MSB first. Writes also carry sixteen data bits. The block implements these commands:

- read, with automatic address increment;
- write-enable and write-disable;
- single-word write and write-all;
- single-word erase and chip erase.

Every programming command is gated by a write-enable latch. A programming command holds the block busy for a parameterised number of system clock cycles. This busy period stands in for the internal program time of a real cell, which is about 10 ms; the default count gives 10 ms at a 50 MHz system clock.

The serial clock and data are sampled with the system clock. Each rising edge of the serial clock moves the frame forward by one bit.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word reads 16'hFFFF, the write-enable latch is clear, busy_o is low and do_o is 0. do_oe_o is high exactly while cs_i is high.
- R2: The start bit is the first 1 sampled on di_i at a rising serial clock edge while cs_i is high. Any 0 bits before it are ignored.
- R3: Read uses opcode 10, then the field {0, A6..A0}. Right after the rising edge of the last address bit, do_o shows a dummy 0. The following rising edges each present one bit of the word, D15 first, down to D0.
- R4: If the serial clock keeps running during a read, the words at the next higher addresses follow back to back. Address 127 wraps to address 0.
- R5: Write uses opcode 01 with the field {0, A6..A0}, then 16 data bits, D15 first. busy_o goes high one cycle after the rising edge of the last data bit and stays high for exactly PROG_CYCLES cycles. After that the new word reads back. A start bit is not accepted while busy_o is high.
- R6: Opcode 00 with field bits [7:6] = 11 sets the write-enable latch; [7:6] = 00 clears it. While the latch is clear, write, erase, write-all and chip erase leave busy_o low and leave every word unchanged.
- R7: Erase uses opcode 11 with the field {0, A6..A0}. It sets that single word to 16'hFFFF and leaves the other words unchanged.
- R8: Write-all uses opcode 00 with field bits [7:6] = 01, then 16 data bits. It stores the data in all 128 words after one busy period.
- R9: Chip erase uses opcode 00 with field bits [7:6] = 10. It sets all 128 words to 16'hFFFF.
- R10: If cs_i drops before a write's data phase is complete, the command is abandoned. No programming takes place, the word is unchanged, and do_o returns to 0 with do_oe_o low.
- R11: For opcode 00, field bits [5:0] are don't-care. Any value there gives the same command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for do_o; low means tri-stated |
| busy_o | output | 1 | High while a programming cycle runs |

## Verification
The bench builds the block with PROG_CYCLES set to 8 and keeps the full 7-bit address. This makes each busy period short enough to count exactly on every write. It also makes it practical to write all 128 addresses with distinct values and to read the whole array back in one auto-increment sweep that crosses the 127-to-0 wrap. Write-all and chip erase are each checked by reading every word back. Disabled, aborted and don't-care-field variants are checked against a model array held in the bench.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_FLD,
        ST_DAT,
        ST_RD,
        ST_HOLD
    } mw_state_e;

    localparam logic [1:0] OPC_EXT  = 2'b00;
    localparam logic [1:0] OPC_WR   = 2'b01;
    localparam logic [1:0] OPC_RD   = 2'b10;
    localparam logic [1:0] OPC_ER   = 2'b11;

    localparam logic [1:0] EXT_WDIS = 2'b00;
    localparam logic [1:0] EXT_WALL = 2'b01;
    localparam logic [1:0] EXT_EALL = 2'b10;
    localparam logic [1:0] EXT_WEN  = 2'b11;

endpackage

// File: rtl/mw_sk_edge.sv
module mw_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk_i,
    output logic rise_o
);

    logic sk_d, sk_q;

    always_comb begin
        sk_d   = sk_i;
        rise_o = sk_i & ~sk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_d;
    end

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        done_o = 1'b0;
        if (start_i) begin
            cnt_d  = CNT_W'(CYCLES - 1);
            busy_d = 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_d = 1'b0;
                done_o = 1'b1;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_all_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en_i && (wr_all_i || wr_addr_i == ADDR_W'(g)))
                word_d = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '1;
            else        word_q <= word_d;
        end

        assign cells[g] = word_q;
    end

    assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o,
    output logic busy_o
);
    import mw_pkg::*;

    localparam int CNT_W = $clog2((DATA_W > FIELD_W) ? DATA_W : FIELD_W);

    typedef struct packed {
        mw_state_e          state;
        logic [1:0]         opc;
        logic [FIELD_W-1:0] fld;
        logic [DATA_W-1:0]  dat;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic               wen;
        logic               dout;
        logic               pend_all;
        logic [ADDR_W-1:0]  pend_addr;
        logic [DATA_W-1:0]  pend_data;
    } mw_regs_t;

    mw_regs_t st_d, st_q;

    logic               sk_rise;
    logic               tmr_busy, tmr_done;
    logic               prog_start;
    logic               mem_we, mem_all;
    logic [ADDR_W-1:0]  mem_addr;
    logic [DATA_W-1:0]  mem_wdata, mem_rdata;
    logic [FIELD_W-1:0] fld_nx;
    logic [DATA_W-1:0]  dat_nx;

    mw_sk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sk_i  (sk_i),
        .rise_o(sk_rise)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(prog_start),
        .busy_o (tmr_busy),
        .done_o (tmr_done)
    );

    mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (mem_we),
        .wr_all_i (mem_all),
        .wr_addr_i(mem_addr),
        .wr_data_i(mem_wdata),
        .rd_addr_i(st_q.addr),
        .rd_data_o(mem_rdata)
    );

    always_comb begin
        st_d       = st_q;
        prog_start = 1'b0;
        fld_nx     = {st_q.fld[FIELD_W-2:0], di_i};
        dat_nx     = {st_q.dat[DATA_W-2:0], di_i};

        if (!cs_i) begin
            st_d.state = ST_IDLE;
            st_d.dout  = 1'b0;
        end else if (sk_rise) begin
            case (st_q.state)
                ST_IDLE: begin
                    if (di_i && !tmr_busy) begin
                        st_d.state = ST_OPC;
                        st_d.cnt   = '0;
                    end
                end
                ST_OPC: begin
                    st_d.opc = {st_q.opc[0], di_i};
                    if (st_q.cnt == CNT_W'(1)) begin
                        st_d.state = ST_FLD;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                ST_FLD: begin
                    st_d.fld = fld_nx;
                    if (st_q.cnt == CNT_W'(FIELD_W - 1)) begin
                        st_d.cnt   = '0;
                        st_d.addr  = fld_nx[ADDR_W-1:0];
                        st_d.state = ST_HOLD;
                        case (st_q.opc)
                            OPC_RD: begin
                                st_d.state = ST_RD;
                                st_d.dout  = 1'b0;
                                st_d.cnt   = CNT_W'(DATA_W - 1);
                            end
                            OPC_WR: begin
                                st_d.state    = ST_DAT;
                                st_d.pend_all = 1'b0;
                            end
                            OPC_ER: begin
                                if (st_q.wen) begin
                                    prog_start     = 1'b1;
                                    st_d.pend_all  = 1'b0;
                                    st_d.pend_addr = fld_nx[ADDR_W-1:0];
                                    st_d.pend_data = '1;
                                end
                            end
                            default: begin
                                case (fld_nx[FIELD_W-1 -: 2])
                                    EXT_WEN:  st_d.wen = 1'b1;
                                    EXT_WDIS: st_d.wen = 1'b0;
                                    EXT_WALL: begin
                                        st_d.state    = ST_DAT;
                                        st_d.pend_all = 1'b1;
                                    end
                                    default: begin
                                        if (st_q.wen) begin
                                            prog_start     = 1'b1;
                                            st_d.pend_all  = 1'b1;
                                            st_d.pend_data = '1;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                ST_DAT: begin
                    st_d.dat = dat_nx;
                    if (st_q.cnt == CNT_W'(DATA_W - 1)) begin
                        st_d.state = ST_HOLD;
                        if (st_q.wen) begin
                            prog_start     = 1'b1;
                            st_d.pend_addr = st_q.addr;
                            st_d.pend_data = dat_nx;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                ST_RD: begin
                    st_d.dout = mem_rdata[st_q.cnt];
                    if (st_q.cnt == '0) begin
                        st_d.cnt  = CNT_W'(DATA_W - 1);
                        st_d.addr = st_q.addr + ADDR_W'(1);
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end

        mem_we    = prog_start | tmr_done;
        mem_all   = prog_start ? st_d.pend_all  : st_q.pend_all;
        mem_addr  = prog_start ? st_d.pend_addr : st_q.pend_addr;
        mem_wdata = prog_start ? '1             : st_q.pend_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    mw_state_e cur_state;
    logic      wen_now;

    assign cur_state = st_q.state;
    assign wen_now   = st_q.wen;
    assign do_o      = st_q.dout;
    assign do_oe_o   = cs_i;
    assign busy_o    = tmr_busy;

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_i,
    input logic      do_o,
    input logic      busy_o,
    input mw_state_e state_i,
    input logic      wen_i,
    input logic      prog_start_i
);

    AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_i == ST_RD) |-> !do_o); // R3

    AST_DATA_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_o) |-> state_i == ST_RD); // R3

    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> (!do_o && state_i == ST_IDLE)); // R10

    AST_LATCH_GATES_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_i |-> wen_i); // R6

    AST_PROG_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_i |=> busy_o); // R5

    AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_i == ST_IDLE) |=> state_i == ST_IDLE); // R5

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_i        (cs_i),
    .do_o        (do_o),
    .busy_o      (busy_o),
    .state_i     (cur_state),
    .wen_i       (wen_now),
    .prog_start_i(prog_start)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    localparam int PROG   = 8;
    localparam int WORDS  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, doe, busy;

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;
    logic [15:0] model [WORDS];

    always #10 clk = ~clk;

    mw_eeprom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(dout), .do_oe_o(doe), .busy_o(busy)
    );

    always @(negedge clk) if (busy) busy_cnt <= busy_cnt + 1;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic sk_bit(input logic b);
        @(negedge clk); di = b; sk = 1'b1;
        @(negedge clk); @(negedge clk); sk = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic cs_up();
        @(negedge clk); cs = 1'b1;
        @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk); cs = 1'b0; di = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic send_head(input logic [1:0] opc, input logic [7:0] fld, input int lead0);
        cs_up();
        for (int i = 0; i < lead0; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        for (int i = 1; i >= 0; i--) sk_bit(opc[i]);
        for (int i = 7; i >= 0; i--) sk_bit(fld[i]);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic prog_cmd(input logic [1:0] opc, input logic [7:0] fld, input logic has_data,
                            input logic [15:0] data, input int lead0, output int busy_seen);
        busy_cnt = 0;
        send_head(opc, fld, lead0);
        if (has_data) for (int i = 15; i >= 0; i--) sk_bit(data[i]);
        cs_down();
        wait_ready();
        busy_seen = busy_cnt;
    endtask

    task automatic read_seq(input int start, input int nwords, input string tag, input string wtag);
        logic [15:0] w;
        send_head(2'b10, {1'b0, 7'(start)}, 0);
        check({tag, " dummy bit"}, int'(dout), 0);
        for (int k = 0; k < nwords; k++) begin
            for (int b = 15; b >= 0; b--) begin
                @(negedge clk); sk = 1'b1;
                @(negedge clk); @(negedge clk); w[b] = dout;
                sk = 1'b0;
                @(negedge clk); @(negedge clk);
            end
            check((k >= WORDS - start) ? wtag : tag, int'(w), int'(model[(start + k) % WORDS]));
        end
        cs_down();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bs;
        for (int a = 0; a < WORDS; a++) model[a] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe low", int'(doe), 0);
        check("R1 do low", int'(dout), 0);
        check("R1 busy low", int'(busy), 0);
        @(negedge clk); cs = 1'b1; @(negedge clk);
        check("R1 oe follows cs", int'(doe), 1);
        cs_down();

        prog_cmd(2'b01, 8'd5, 1'b1, 16'h1234, 0, bs);
        check("R6 latch clear after reset, no busy", bs, 0);
        read_seq(5, 1, "R6 word unchanged", "R6");

        prog_cmd(2'b00, 8'b11_100101, 1'b0, 16'h0, 0, bs);
        check("R11 enable with junk low bits, no busy", bs, 0);

        for (int a = 0; a < WORDS; a++) begin
            logic [15:0] v;
            v = 16'((a * 16'h0137) ^ 16'h5A3C ^ (a << 9));
            prog_cmd(2'b01, {1'b0, 7'(a)}, 1'b1, v, (a % 4 == 0) ? 2 : 0, bs);
            model[a] = v;
            check((a % 4 == 0) ? "R2 leading zeros, R5 busy length" : "R5 busy length", bs, PROG);
        end
        read_seq(0, WORDS + 1, "R3 read word", "R4 wrap word");
        read_seq(126, 4, "R4 increment", "R4 wrap 127->0");

        prog_cmd(2'b11, 8'd10, 1'b0, 16'h0, 0, bs);
        model[10] = 16'hFFFF;
        check("R7 erase busy", bs, PROG);
        read_seq(9, 3, "R7 erase neighbours", "R7");

        prog_cmd(2'b00, 8'b00_011011, 1'b0, 16'h0, 0, bs);
        prog_cmd(2'b01, 8'd11, 1'b1, 16'hBEEF, 0, bs);
        check("R6 R11 write after disable, no busy", bs, 0);
        prog_cmd(2'b11, 8'd12, 1'b0, 16'h0, 0, bs);
        check("R6 erase after disable, no busy", bs, 0);
        prog_cmd(2'b00, 8'b01_000000, 1'b1, 16'h0F0F, 0, bs);
        check("R6 write-all after disable, no busy", bs, 0);
        prog_cmd(2'b00, 8'b10_111111, 1'b0, 16'h0, 0, bs);
        check("R6 chip erase after disable, no busy", bs, 0);
        read_seq(11, 2, "R6 words kept", "R6");

        prog_cmd(2'b00, 8'b11_000000, 1'b0, 16'h0, 0, bs);
        busy_cnt = 0;
        send_head(2'b01, 8'd20, 0);
        for (int i = 0; i < 8; i++) sk_bit(1'(i & 1));
        @(negedge clk); cs = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10 oe low on abort", int'(doe), 0);
        check("R10 do low on abort", int'(dout), 0);
        repeat (PROG + 4) @(negedge clk);
        check("R10 no programming", busy_cnt, 0);
        read_seq(20, 1, "R10 word unchanged", "R10");

        prog_cmd(2'b00, 8'b01_110011, 1'b1, 16'hA55A, 0, bs);
        check("R8 write-all busy", bs, PROG);
        for (int a = 0; a < WORDS; a++) model[a] = 16'hA55A;
        read_seq(0, WORDS, "R8 every word", "R8");

        prog_cmd(2'b00, 8'b10_001100, 1'b0, 16'h0, 0, bs);
        check("R9 chip erase busy", bs, PROG);
        for (int a = 0; a < WORDS; a++) model[a] = 16'hFFFF;
        read_seq(0, WORDS, "R9 every word", "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule